// File: doc/BRIEF.md
# Slave-mode timer controller

This block sits beside a timer counter and decides when and how that counter moves. It takes a trigger, chosen from a small list of trigger outputs of neighbouring timers, or a pair of quadrature inputs, and turns them into counting steps, counter clears and update requests. A 3-bit mode field gives the chosen trigger one job: clock the counter, gate it, start it, clear it, or none of these. The mode field can also make the counter follow a quadrature encoder.

The counter is built in. It counts between zero and an auto-reload limit and wraps at both ends. It raises an update request whenever it wraps or is cleared. A software set/clear pair drives the counter enable flag, and in start mode a trigger edge can also set that flag. Every external input passes through a two-flop synchroniser. Edges are taken from the synchronised levels, so each edge acts for exactly one cycle.

Top module: `slave_timer_ctrl`

## Requirements
- R1: After reset, `count_o` is 0 and `cnt_en_o`, `dir_o`, `cnt_rst_o` and `upd_o` are all 0.
- R2: Mode 0 (free-running): while the enable flag is set, the counter steps up by one each cycle. A `sw_set_i` pulse sets the flag and a `sw_clr_i` pulse clears it. When both are high, clear wins. While the flag is clear and the mode is not 4, the count does not change.
- R3: An up step from a count equal to or above `arr_i` gives 0. In the cycle of that step, `upd_o` is high.
- R4: Mode 1 (encoder, counts on B): each edge of the synchronised B input steps the counter. The step is down when the levels of A and B after the edge differ, and up when they are equal. Edges of A do not count.
- R5: Mode 2 (encoder, counts on A): each edge of the synchronised A input steps the counter. The step is down when the levels of A and B after the edge are equal, and up when they differ. Edges of B do not count.
- R6: Mode 3 (encoder, both inputs): an edge of either input steps the counter, using the R4 rule for B edges and the R5 rule for A edges. If both inputs change in the same cycle, there is no step. A down step from 0 gives `arr_i`, with `upd_o` high. `dir_o` holds the direction of the last step (1 = down).
- R7: Mode 4 (clear): a rising edge of the trigger clears the counter to 0, whatever the enable flag. In that cycle `cnt_rst_o` and `upd_o` are high. A falling edge has no effect, and between edges the counter steps as in R2.
- R8: Mode 5 (gated): with the flag set, the counter steps once per cycle while the synchronised trigger is high. When the trigger is low the counter holds its value.
- R9: Mode 6 (start): a rising trigger edge sets the enable flag without changing the count. A falling edge does not clear the flag; only `sw_clr_i` does. In any other mode the trigger never sets the flag.
- R10: Mode 7 (external clock): with the flag set, each rising trigger edge steps the counter up by one.
- R11: `tsel_i` values 0 to NSRC-1 pick bit `tsel_i` of `trg_src_i` as the trigger. Larger values give a trigger held low, and the unselected bits have no effect.
- R12: When `trg_inv_i` is 1, the selected source is inverted before synchronisation, so a falling source edge acts as a rising trigger edge.
- R13: An input change driven before clock edge k first moves `count_o` at edge k+2 (two synchroniser stages, then the counter register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Slave mode (0..7, see R2-R10) |
| tsel_i | input | 3 | Trigger source index |
| trg_inv_i | input | 1 | Invert the selected trigger |
| trg_src_i | input | NSRC | Trigger outputs of other timers |
| enc_a_i | input | 1 | Quadrature input A |
| enc_b_i | input | 1 | Quadrature input B |
| sw_set_i | input | 1 | Set the counter enable flag |
| sw_clr_i | input | 1 | Clear the counter enable flag (priority) |
| arr_i | input | CW | Auto-reload limit |
| count_o | output | CW | Counter value |
| dir_o | output | 1 | Last step direction, 1 = down |
| cnt_en_o | output | 1 | Counter enable flag |
| cnt_rst_o | output | 1 | Counter clear pulse (mode 4) |
| upd_o | output | 1 | Update request: wrap or clear |

## Verification
A corrupted synchroniser or edge register shows up as `count_o` moving one edge too early or too late relative to R13. It can also show as a step on a falling edge, or a step taken twice for one edge, all visible within three cycles of the input change. A wrong enable flag shows in `cnt_en_o` at once, and in the count on the next cycle. A wrong direction bit shows on `dir_o` and in the count at the next encoder step. The randomised quadrature walks take the count across both wrap points, so a wrong wrap value shows up by the end of each walk.

// File: rtl/slave_timer_ctrl.sv
`timescale 1ns/1ps
module slave_timer_ctrl #(
  parameter int CW   = 16,
  parameter int NSRC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_i,
  input  logic [2:0]    tsel_i,
  input  logic          trg_inv_i,
  input  logic [NSRC-1:0] trg_src_i,
  input  logic          enc_a_i,
  input  logic          enc_b_i,
  input  logic          sw_set_i,
  input  logic          sw_clr_i,
  input  logic [CW-1:0] arr_i,
  output logic [CW-1:0] count_o,
  output logic          dir_o,
  output logic          cnt_en_o,
  output logic          cnt_rst_o,
  output logic          upd_o
);
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [2:0] M_FREE = 3'd0, M_ENC1 = 3'd1, M_ENC2 = 3'd2, M_ENC3 = 3'd3,
                         M_CLR  = 3'd4, M_GATE = 3'd5, M_START = 3'd6, M_EXT = 3'd7;

  logic [2:0] ts, sa, sb;
  logic       trg_pick, t_lvl, t_rise, a_lvl, b_lvl, a_edge, b_edge;
  logic       step, down, clr_evt, wrap, en_q, dir_q;
  logic [CW-1:0] cnt_q, cnt_d;

  assign trg_pick = (int'(tsel_i) < NSRC) ? trg_src_i[tsel_i[SW-1:0]] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts <= '0;
      sa <= '0;
      sb <= '0;
    end else begin
      ts <= {ts[1:0], trg_pick ^ trg_inv_i};
      sa <= {sa[1:0], enc_a_i};
      sb <= {sb[1:0], enc_b_i};
    end
  end

  assign t_lvl  = ts[1];
  assign t_rise = ts[1] & ~ts[2];
  assign a_lvl  = sa[1];
  assign b_lvl  = sb[1];
  assign a_edge = sa[1] ^ sa[2];
  assign b_edge = sb[1] ^ sb[2];

  always_comb begin
    step = 1'b0;
    down = 1'b0;
    unique case (mode_i)
      M_FREE:  step = en_q;
      M_ENC1: begin
        step = en_q & b_edge & ~a_edge;
        down = a_lvl ^ b_lvl;
      end
      M_ENC2: begin
        step = en_q & a_edge & ~b_edge;
        down = ~(a_lvl ^ b_lvl);
      end
      M_ENC3: begin
        step = en_q & (a_edge ^ b_edge);
        down = b_edge ? (a_lvl ^ b_lvl) : ~(a_lvl ^ b_lvl);
      end
      M_CLR:   step = en_q;
      M_GATE:  step = en_q & t_lvl;
      M_START: step = en_q;
      M_EXT:   step = en_q & t_rise;
      default: step = 1'b0;
    endcase
  end

  assign clr_evt = (mode_i == M_CLR) & t_rise;
  assign wrap    = step & (down ? (cnt_q == '0) : (cnt_q >= arr_i));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_evt)
      cnt_d = '0;
    else if (step && down)
      cnt_d = (cnt_q == '0) ? arr_i : cnt_q - CW'(1);
    else if (step)
      cnt_d = (cnt_q >= arr_i) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (step)
        dir_q <= down;
      if (sw_clr_i)
        en_q <= 1'b0;
      else if (sw_set_i || (mode_i == M_START && t_rise))
        en_q <= 1'b1;
    end
  end

  assign count_o   = cnt_q;
  assign dir_o     = dir_q;
  assign cnt_en_o  = en_q;
  assign cnt_rst_o = clr_evt;
  assign upd_o     = clr_evt | wrap;
endmodule

module slave_timer_ctrl_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode_i,
  input logic          sw_set_i,
  input logic          sw_clr_i,
  input logic [CW-1:0] arr_i,
  input logic [CW-1:0] count_o,
  input logic          cnt_en_o,
  input logic          cnt_rst_o,
  input logic          upd_o
);
  p_clr_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr_i |=> !cnt_en_o);

  p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en_o && mode_i != 3'd4) |=> $stable(count_o));

  p_wrap_upd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en_o && mode_i == 3'd0 && count_o >= arr_i) |-> upd_o);

  p_enc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd1 || mode_i == 3'd2 || mode_i == 3'd3) |=>
      (count_o == $past(count_o) || count_o == $past(count_o) + CW'(1) ||
       count_o == $past(count_o) - CW'(1) || count_o == '0 || count_o == $past(arr_i)));

  p_clr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst_o |=> (count_o == '0));

  p_clr_upd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst_o |-> upd_o);

  p_no_self_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en_o && !sw_set_i && mode_i != 3'd6) |=> !cnt_en_o);
endmodule

bind slave_timer_ctrl slave_timer_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sw_set_i(sw_set_i), .sw_clr_i(sw_clr_i),
  .arr_i(arr_i), .count_o(count_o), .cnt_en_o(cnt_en_o), .cnt_rst_o(cnt_rst_o), .upd_o(upd_o)
);

// File: tb/slave_timer_ctrl_bench.sv
`timescale 1ns/1ps
module slave_timer_ctrl_bench;
  localparam int CW = 16, NSRC = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode_i = '0, tsel_i = '0;
  logic trg_inv_i = 1'b0, enc_a_i = 1'b0, enc_b_i = 1'b0, sw_set_i = 1'b0, sw_clr_i = 1'b0;
  logic [NSRC-1:0] trg_src_i = '0;
  logic [CW-1:0] arr_i = '0;
  logic [CW-1:0] count_o;
  logic dir_o, cnt_en_o, cnt_rst_o, upd_o;

  slave_timer_ctrl #(.CW(CW), .NSRC(NSRC)) u_slave_timer_ctrl (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int arr_v, exp_cnt, phase;
  bit exp_dir, done = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int up_f(int c);  return (c >= arr_v) ? 0 : c + 1;  endfunction
  function automatic int dn_f(int c);  return (c == 0) ? arr_v : c - 1;  endfunction

  task automatic tick(int n);  repeat (n) @(negedge clk);  endtask

  task automatic do_reset();
    rst_n = 1'b0; mode_i = '0; tsel_i = '0; trg_inv_i = 0; trg_src_i = '0;
    enc_a_i = 0; enc_b_i = 0; sw_set_i = 0; sw_clr_i = 0;
    tick(3); rst_n = 1'b1; tick(1);
    exp_cnt = 0; exp_dir = 0; phase = 0;
  endtask

  task automatic pulse_set();  sw_set_i = 1; tick(1); sw_set_i = 0;  endtask
  task automatic pulse_clr();  sw_clr_i = 1; tick(1); sw_clr_i = 0;  endtask

  task automatic src_pulses(int bitn, int n);
    for (int i = 0; i < n; i++) begin
      trg_src_i[bitn] = 1'b1; tick(3);
      trg_src_i[bitn] = 1'b0; tick(3);
    end
  endtask

  task automatic set_phase();
    enc_a_i = (phase == 1 || phase == 2);
    enc_b_i = (phase >= 2);
  endtask

  task automatic enc_walk(int m, int steps);
    for (int i = 0; i < steps; i++) begin
      bit fwd, cha;
      fwd = 1'($urandom % 2);
      cha = fwd ? (phase % 2 == 0) : (phase % 2 == 1);
      phase = fwd ? (phase + 1) % 4 : (phase + 3) % 4;
      set_phase();
      if ((m == 1 && !cha) || (m == 2 && cha) || m == 3) begin
        exp_cnt = fwd ? up_f(exp_cnt) : dn_f(exp_cnt);
        exp_dir = !fwd;
      end
      tick(4);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    arr_v = 1000; arr_i = CW'(arr_v);
    do_reset();
    // R1
    chk("R1 count", count_o, 0);
    chk("R1 en", cnt_en_o, 0);
    chk("R1 dir", dir_o, 0);
    chk("R1 pulses", {cnt_rst_o, upd_o}, 0);

    // R2 free running
    pulse_set();
    chk("R2 start count", count_o, 0);
    tick(20);
    chk("R2 run", count_o, 20);
    chk("R2 en", cnt_en_o, 1);
    pulse_clr();
    tick(5);
    chk("R2 stop hold", count_o, 21);
    chk("R2 en off", cnt_en_o, 0);
    sw_set_i = 1; sw_clr_i = 1; tick(1); sw_set_i = 0; sw_clr_i = 0;
    chk("R2 clr priority", cnt_en_o, 0);

    // R3 wrap
    do_reset();
    arr_v = 5; arr_i = 5;
    pulse_set();
    tick(5);
    chk("R3 at limit", count_o, 5);
    chk("R3 upd", upd_o, 1);
    tick(1);
    chk("R3 wrapped", count_o, 0);
    chk("R3 upd gone", upd_o, 0);

    // R13, R10 external clock
    do_reset();
    arr_v = 1000; arr_i = CW'(arr_v);
    mode_i = 3'd7; pulse_set();
    trg_src_i[0] = 1; tick(2);
    chk("R13 not yet", count_o, 0);
    tick(1);
    chk("R13 latency", count_o, 1);
    trg_src_i[0] = 0; tick(3);
    src_pulses(0, 7);
    chk("R10 ext clock", count_o, 8);

    // R11 source select
    tsel_i = 3'd2;
    src_pulses(1, 5);
    chk("R11 other source ignored", count_o, 8);
    src_pulses(2, 3);
    chk("R11 selected source", count_o, 11);
    tsel_i = 3'd5;
    for (int i = 0; i < 3; i++) begin
      trg_src_i = '1; tick(3); trg_src_i = '0; tick(3);
    end
    chk("R11 out of range", count_o, 11);

    // R12 invert
    tsel_i = 3'd0; tick(3);
    trg_inv_i = 1; tick(4);
    chk("R12 invert rise", count_o, 12);
    src_pulses(0, 1);
    chk("R12 falling source counts", count_o, 13);
    trg_inv_i = 0; tick(4);
    chk("R12 restore", count_o, 13);

    // R7 clear mode (flag still set, counting each cycle)
    mode_i = 3'd4;
    trg_src_i[0] = 1; tick(2);
    chk("R7 clear pulse", cnt_rst_o, 1);
    chk("R7 upd", upd_o, 1);
    tick(1);
    chk("R7 cleared", count_o, 0);
    tick(1);
    chk("R7 resumes", count_o, 1);
    chk("R7 pulse once", cnt_rst_o, 0);
    trg_src_i[0] = 0; tick(5);
    chk("R7 fall ignored", count_o, 6);

    // R8 gated
    do_reset();
    mode_i = 3'd5; pulse_set();
    tick(4);
    chk("R8 gate low hold", count_o, 0);
    trg_src_i[0] = 1; tick(10); trg_src_i[0] = 0; tick(6);
    chk("R8 gated count", count_o, 10);
    trg_src_i[0] = 1; tick(4); trg_src_i[0] = 0; tick(6);
    chk("R8 resumes keeps value", count_o, 14);

    // R9 start mode
    do_reset();
    mode_i = 3'd6; tick(4);
    chk("R9 idle", count_o, 0);
    trg_src_i[0] = 1; tick(3);
    chk("R9 started", cnt_en_o, 1);
    chk("R9 no reset", count_o, 0);
    tick(1);
    chk("R9 counting", count_o, 1);
    trg_src_i[0] = 0; tick(5);
    chk("R9 fall keeps run", count_o, 6);
    pulse_clr();
    chk("R9 sw stop", cnt_en_o, 0);
    mode_i = 3'd0; tick(2);
    trg_src_i[0] = 1; tick(4); trg_src_i[0] = 0; tick(4);
    chk("R9 other mode no start", cnt_en_o, 0);

    // R4, R5, R6 encoder walks
    for (int m = 1; m <= 3; m++) begin
      do_reset();
      arr_v = 5 + int'($urandom % 30); arr_i = CW'(arr_v);
      mode_i = 3'(m); pulse_set();
      enc_walk(m, 80);
      if (m == 1) begin chk("R4 enc count", count_o, exp_cnt); chk("R4 dir", dir_o, exp_dir); end
      if (m == 2) begin chk("R5 enc count", count_o, exp_cnt); chk("R5 dir", dir_o, exp_dir); end
      if (m == 3) begin chk("R6 enc count", count_o, exp_cnt); chk("R6 dir", dir_o, exp_dir); end
    end

    // R6 directed: down wrap and simultaneous edges
    do_reset();
    arr_v = 9; arr_i = 9; mode_i = 3'd3; pulse_set();
    phase = 3; set_phase(); tick(2);
    chk("R6 down wrap upd", upd_o, 1);
    tick(2);
    chk("R6 down wrap", count_o, 9);
    chk("R6 dir down", dir_o, 1);
    phase = 1; set_phase(); tick(4);
    chk("R6 double edge ignored", count_o, 9);
    exp_cnt = 9; exp_dir = 1;
    enc_walk(3, 40);
    chk("R6 walk after glitch", count_o, exp_cnt);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule